// File: doc/BRIEF.md
# Inter-processor doorbell signal controller

This block lets a local processor ring doorbells on other processors and take incoming doorbells as one level interrupt. Every doorbell is named by one 32-bit identifier: the upper half is the client number and the lower half is the signal number within that client. Software rings a remote doorbell by writing the identifier to a send register. The block then puts out a one-cycle send event that the interconnect carries to the far side.

Incoming doorbells arrive on a set port and are held in a pending array, one bit for each client/signal pair inside the configured range. A matching enable array gates them onto the summary interrupt. A service routine reads the receive register to get the identifier of the next enabled pending doorbell and writes that identifier back to the clear register. It repeats until the receive register reads all ones. Enabling, masking and clearing all work by writing an identifier to a dedicated register, never by writing bit masks. One extra register drops every pending doorbell of a whole client at once.

Top module: `ipc_sig_ctrl`

## Requirements
- R1: After reset no signal is pending and every signal is disabled. The receive register (offset 0x10) reads 0xFFFFFFFF and `irq` is low.
- R2: A bus write to offset 0x0C raises `send_valid` for exactly the cycle after the write, with `send_id` equal to the written word (client in bits 31:16, signal in bits 15:0). A write to any other offset leaves `send_valid` low.
- R3: A pulse on `sig_set_valid` with an in-range identifier sets that signal's pending bit whether or not the signal is enabled.
- R4: Writing an identifier to offset 0x14 enables that one signal. Writing it to offset 0x18 masks that one signal. Its pending bit is left untouched in both cases.
- R5: Writing an identifier to offset 0x1C clears the pending bit of that signal only.
- R6: Writing a client number in bits 15:0 of the word to offset 0x38 clears every pending bit of that client.
- R7: An identifier whose client is at or above NUM_CLIENTS, or whose signal is at or above NUM_SIGNALS, changes no pending or enable state. This holds on the set port and on the enable, mask, clear and client-clear writes.
- R8: Reading offset 0x10 returns the enabled pending signal with the lowest client number, and within that client the lowest signal number. It returns 0xFFFFFFFF when no enabled signal is pending.
- R9: `irq` is high exactly while at least one enabled signal is pending. A masked pending signal raises `irq` in the cycle after it is enabled.
- R10: When an incoming set and a clear (single or client) hit the same signal in the same cycle, the signal ends up pending.
- R11: Reads of every offset other than 0x10 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| send_valid | output | 1 | One-cycle outbound doorbell event |
| send_id | output | 32 | Identifier carried by the outbound event |
| sig_set_valid | input | 1 | Inbound doorbell strobe |
| sig_set_id | input | 32 | Identifier of the inbound doorbell |
| irq | output | 1 | Active-high level summary interrupt |

## Verification
A wrong pending or enable bit shows up at once in the receive register and on `irq`. The receive value is combinational over the state flops, so a bad bit is visible in the first cycle after the write or set edge that corrupted it. The bench keeps its own pending and enable model and compares the receive register and `irq` after every operation. A priority error therefore shows as a wrong identifier, and a lost or stray bit shows as a wrong level, without waiting for a drain loop. Send events are checked in the single cycle where they must appear and in the cycles where they must not.

// File: rtl/ipc_sig_pkg.sv
package ipc_sig_pkg;
  // Register byte offsets; software depends on these values
  localparam logic [7:0] OFS_SEND = 8'h0C;
  localparam logic [7:0] OFS_RX   = 8'h10;
  localparam logic [7:0] OFS_EN   = 8'h14;
  localparam logic [7:0] OFS_DIS  = 8'h18;
  localparam logic [7:0] OFS_CLR  = 8'h1C;
  localparam logic [7:0] OFS_CCLR = 8'h38;

  localparam logic [31:0] NO_SIGNAL = 32'hFFFF_FFFF;

  typedef struct packed {
    logic [15:0] client;
    logic [15:0] signal;
  } sig_id_t;
endpackage

// File: rtl/ipc_sig_decode.sv
// Turns an identifier into a one-hot vector over the held signals.
// An identifier out of range gives an all-zero vector.
module ipc_sig_decode #(
  parameter int NUM_CLIENTS = 4,
  parameter int NUM_SIGNALS = 8,
  localparam int NBITS = NUM_CLIENTS * NUM_SIGNALS
) (
  input  ipc_sig_pkg::sig_id_t id,
  output logic [NBITS-1:0]     onehot
);
  for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_client
    for (genvar s = 0; s < NUM_SIGNALS; s++) begin : g_signal
      assign onehot[c*NUM_SIGNALS + s] = (id.client == 16'(c)) && (id.signal == 16'(s));
    end
  end
endmodule

// File: rtl/ipc_sig_client_mask.sv
// Selects all bits belonging to one client number.
module ipc_sig_client_mask #(
  parameter int NUM_CLIENTS = 4,
  parameter int NUM_SIGNALS = 8,
  localparam int NBITS = NUM_CLIENTS * NUM_SIGNALS
) (
  input  logic [15:0]      client,
  output logic [NBITS-1:0] mask
);
  for (genvar c = 0; c < NUM_CLIENTS; c++) begin : g_client
    assign mask[c*NUM_SIGNALS +: NUM_SIGNALS] = {NUM_SIGNALS{client == 16'(c)}};
  end
endmodule

// File: rtl/ipc_sig_prio.sv
// Lowest set index wins: lowest client first, then lowest signal.
module ipc_sig_prio #(
  parameter int NUM_CLIENTS = 4,
  parameter int NUM_SIGNALS = 8,
  localparam int NBITS = NUM_CLIENTS * NUM_SIGNALS
) (
  input  logic [NBITS-1:0] req,
  output logic             found,
  output logic [31:0]      id
);
  always_comb begin
    found = 1'b0;
    id    = ipc_sig_pkg::NO_SIGNAL;
    for (int i = NBITS - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        id    = {16'(i / NUM_SIGNALS), 16'(i % NUM_SIGNALS)};
      end
    end
  end
endmodule

// File: rtl/ipc_sig_ctrl.sv
module ipc_sig_ctrl #(
  parameter int ADDR_W      = 8,
  parameter int NUM_CLIENTS = 4,
  parameter int NUM_SIGNALS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              send_valid,
  output logic [31:0]       send_id,
  input  logic              sig_set_valid,
  input  logic [31:0]       sig_set_id,
  output logic              irq
);
  import ipc_sig_pkg::*;

  localparam int NBITS = NUM_CLIENTS * NUM_SIGNALS;

  // Reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Write decode
  logic wr_send, wr_en, wr_dis, wr_clr, wr_cclr;
  assign wr_send = bus_we && (bus_addr == ADDR_W'(OFS_SEND));
  assign wr_en   = bus_we && (bus_addr == ADDR_W'(OFS_EN));
  assign wr_dis  = bus_we && (bus_addr == ADDR_W'(OFS_DIS));
  assign wr_clr  = bus_we && (bus_addr == ADDR_W'(OFS_CLR));
  assign wr_cclr = bus_we && (bus_addr == ADDR_W'(OFS_CCLR));

  logic [NBITS-1:0] wr_hot, set_hot, cl_mask;

  ipc_sig_decode #(.NUM_CLIENTS(NUM_CLIENTS), .NUM_SIGNALS(NUM_SIGNALS)) u_dec_wr (
    .id(sig_id_t'(bus_wdata)), .onehot(wr_hot));
  ipc_sig_decode #(.NUM_CLIENTS(NUM_CLIENTS), .NUM_SIGNALS(NUM_SIGNALS)) u_dec_set (
    .id(sig_id_t'(sig_set_id)), .onehot(set_hot));
  ipc_sig_client_mask #(.NUM_CLIENTS(NUM_CLIENTS), .NUM_SIGNALS(NUM_SIGNALS)) u_cmask (
    .client(bus_wdata[15:0]), .mask(cl_mask));

  // State
  logic [NBITS-1:0] pend_q, pend_d, en_q, en_d;
  logic             pend_ce, en_ce;
  logic             send_valid_q;
  logic [31:0]      send_id_q;

  always_comb begin
    pend_d = pend_q;
    if (wr_clr)        pend_d = pend_d & ~wr_hot;
    if (wr_cclr)       pend_d = pend_d & ~cl_mask;
    if (sig_set_valid) pend_d = pend_d | set_hot;   // arrival beats clear
    pend_ce = sig_set_valid || wr_clr || wr_cclr;
  end

  always_comb begin
    en_d = en_q;
    if (wr_en)  en_d = en_d | wr_hot;
    if (wr_dis) en_d = en_d & ~wr_hot;
    en_ce = wr_en || wr_dis;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pend_q       <= '0;
      en_q         <= '0;
      send_valid_q <= 1'b0;
      send_id_q    <= '0;
    end else begin
      if (pend_ce) pend_q <= pend_d;
      if (en_ce)   en_q   <= en_d;
      send_valid_q <= wr_send;
      if (wr_send) send_id_q <= bus_wdata;
    end
  end

  assign send_valid = send_valid_q;
  assign send_id    = send_id_q;

  // Receive side
  logic        hit_found;
  logic [31:0] hit_id;

  ipc_sig_prio #(.NUM_CLIENTS(NUM_CLIENTS), .NUM_SIGNALS(NUM_SIGNALS)) u_prio (
    .req(pend_q & en_q), .found(hit_found), .id(hit_id));

  assign irq = hit_found;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_RX)) bus_rdata = hit_id;
  end
endmodule

// File: rtl/ipc_sig_ctrl_chk.sv
module ipc_sig_ctrl_chk #(
  parameter int ADDR_W      = 8,
  parameter int NUM_CLIENTS = 4,
  parameter int NUM_SIGNALS = 8,
  localparam int NBITS = NUM_CLIENTS * NUM_SIGNALS,
  localparam int IW    = (NBITS > 1) ? $clog2(NBITS) : 1
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              send_valid,
  input logic [31:0]       send_id,
  input logic              sig_set_valid,
  input logic [31:0]       sig_set_id,
  input logic              irq,
  input logic [NBITS-1:0]  pend_q,
  input logic [NBITS-1:0]  en_q
);
  import ipc_sig_pkg::*;

  logic          wr_in, set_in;
  logic [IW-1:0] wr_ix, set_ix, wr_ix_q, set_ix_q;

  assign wr_in  = (int'(bus_wdata[31:16]) < NUM_CLIENTS) && (int'(bus_wdata[15:0]) < NUM_SIGNALS);
  assign set_in = (int'(sig_set_id[31:16]) < NUM_CLIENTS) && (int'(sig_set_id[15:0]) < NUM_SIGNALS);
  assign wr_ix  = IW'(int'(bus_wdata[31:16]) * NUM_SIGNALS + int'(bus_wdata[15:0]));
  assign set_ix = IW'(int'(sig_set_id[31:16]) * NUM_SIGNALS + int'(sig_set_id[15:0]));

  always_ff @(posedge clk) begin
    wr_ix_q  <= wr_ix;
    set_ix_q <= set_ix;
  end

  // R2
  send_event_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_addr == ADDR_W'(OFS_SEND)) |=> (send_valid && send_id == $past(bus_wdata)));

  // R2
  send_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_we && bus_addr == ADDR_W'(OFS_SEND)) |=> !send_valid);

  // R3
  set_pending_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sig_set_valid && set_in) |=> pend_q[set_ix_q]);

  // R4
  enable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_addr == ADDR_W'(OFS_EN) && wr_in) |=> en_q[wr_ix_q]);

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_addr == ADDR_W'(OFS_CLR) && wr_in &&
     !(sig_set_valid && sig_set_id == bus_wdata)) |=> !pend_q[wr_ix_q]);

  // R8
  rx_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == ADDR_W'(OFS_RX) && irq) |-> bus_rdata != NO_SIGNAL);

  // R8
  rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == ADDR_W'(OFS_RX) && !irq) |-> bus_rdata == NO_SIGNAL);

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr != ADDR_W'(OFS_RX)) |-> bus_rdata == '0);
endmodule

bind ipc_sig_ctrl ipc_sig_ctrl_chk #(
  .ADDR_W(ADDR_W), .NUM_CLIENTS(NUM_CLIENTS), .NUM_SIGNALS(NUM_SIGNALS)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .send_valid(send_valid),
  .send_id(send_id), .sig_set_valid(sig_set_valid), .sig_set_id(sig_set_id),
  .irq(irq), .pend_q(pend_q), .en_q(en_q)
);

// File: tb/ipc_sig_ctrl_tb.sv
`timescale 1ns/1ps
module ipc_sig_ctrl_tb;
  localparam int NC = 4;
  localparam int NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h10;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        send_valid;
  logic [31:0] send_id;
  logic        sig_set_valid = 1'b0;
  logic [31:0] sig_set_id = '0;
  logic        irq;

  always #4 clk = ~clk;   // 125 MHz

  ipc_sig_ctrl #(.ADDR_W(8), .NUM_CLIENTS(NC), .NUM_SIGNALS(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .send_valid(send_valid),
    .send_id(send_id), .sig_set_valid(sig_set_valid), .sig_set_id(sig_set_id),
    .irq(irq));

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;
  bit  pend_m [NC][NS];
  bit  en_m   [NC][NS];

  function automatic logic [31:0] exp_rx();
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++)
        if (pend_m[c][s] && en_m[c][s]) return {16'(c), 16'(s)};
    return 32'hFFFF_FFFF;
  endfunction

  function automatic bit exp_irq();
    return exp_rx() != 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] mk(input int c, input int s);
    return {16'(c), 16'(s)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Applies one bus write and/or inbound set, then compares against the model
  task automatic op(input bit we, input logic [7:0] a, input logic [31:0] wd,
                    input bit st, input logic [31:0] sid, input string tag);
    int  wc, ws, sc, ss;
    bit  winr, sinr;
    bus_we = we; bus_addr = a; bus_wdata = wd;
    sig_set_valid = st; sig_set_id = sid;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; sig_set_valid = 1'b0; bus_addr = 8'h10;
    // model update: clears, then set (set wins, R10); out-of-range ignored (R7)
    wc = int'(wd[31:16]); ws = int'(wd[15:0]);
    sc = int'(sid[31:16]); ss = int'(sid[15:0]);
    winr = (wc < NC) && (ws < NS);
    sinr = (sc < NC) && (ss < NS);
    if (we && winr && a == 8'h14) en_m[wc][ws] = 1'b1;
    if (we && winr && a == 8'h18) en_m[wc][ws] = 1'b0;
    if (we && winr && a == 8'h1C) pend_m[wc][ws] = 1'b0;
    if (we && a == 8'h38 && int'(wd[15:0]) < NC)
      for (int s = 0; s < NS; s++) pend_m[int'(wd[15:0])][s] = 1'b0;
    if (st && sinr) pend_m[sc][ss] = 1'b1;
    #1;
    // R2: send event exactly in the cycle after a send write
    check({tag, " R2 send_valid"}, {31'd0, send_valid}, {31'd0, we && a == 8'h0C});
    if (we && a == 8'h0C) check({tag, " R2 send_id"}, send_id, wd);
    // R8 receive register, R9 interrupt level
    check({tag, " R8 rx"}, bus_rdata, exp_rx());
    check({tag, " R9 irq"}, {31'd0, irq}, {31'd0, exp_irq()});
  endtask

  task automatic rd_zero(input logic [7:0] a);
    bus_addr = a;
    #1;
    check("R11 unmapped read", bus_rdata, 32'd0);
    bus_addr = 8'h10;
    #1;
  endtask

  initial begin
    logic [7:0] addrs [6];
    int         cnt;
    logic [31:0] id;
    addrs[0] = 8'h0C; addrs[1] = 8'h14; addrs[2] = 8'h18;
    addrs[3] = 8'h1C; addrs[4] = 8'h38; addrs[5] = 8'h10;
    void'($urandom(32'd20240611));
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) begin pend_m[c][s] = 0; en_m[c][s] = 0; end

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    #1;
    // R1 reset state
    check("R1 rx after reset", bus_rdata, 32'hFFFF_FFFF);
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    check("R1 send_valid after reset", {31'd0, send_valid}, 32'd0);
    rd_zero(8'h0C); rd_zero(8'h14); rd_zero(8'h38); rd_zero(8'h3C); rd_zero(8'h00);

    // R3/R9: masked arrival stays pending without interrupt, then fires on enable
    op(0, 8'h10, 0, 1, mk(1, 2), "R3 masked set");
    op(1, 8'h14, mk(1, 2), 0, 0, "R9 enable pending");
    // R4: disable masks it, pending kept, re-enable restores
    op(1, 8'h18, mk(1, 2), 0, 0, "R4 disable");
    op(1, 8'h14, mk(1, 2), 0, 0, "R4 re-enable");
    // R8 priority: lower client beats, then lower signal
    op(1, 8'h14, mk(0, 5), 0, 0, "R8 en 0.5");
    op(1, 8'h14, mk(0, 3), 0, 0, "R8 en 0.3");
    op(0, 8'h10, 0, 1, mk(0, 5), "R8 set 0.5");
    op(0, 8'h10, 0, 1, mk(0, 3), "R8 set 0.3");
    // R5: clear one only
    op(1, 8'h1C, mk(0, 3), 0, 0, "R5 clear 0.3");
    // R7: out-of-range ids ignored
    op(0, 8'h10, 0, 1, mk(NC, 0), "R7 set bad client");
    op(0, 8'h10, 0, 1, mk(0, NS), "R7 set bad signal");
    op(1, 8'h1C, mk(0, 5 + 16 * NS), 0, 0, "R7 clear bad");
    op(1, 8'h18, mk(NC + 1, 5), 0, 0, "R7 disable bad");
    op(1, 8'h38, 32'(NC), 0, 0, "R7 client clear bad");
    // R10: set and clear of the same signal in one cycle
    op(1, 8'h1C, mk(0, 5), 1, mk(0, 5), "R10 set vs clear");
    op(1, 8'h38, 32'd1, 1, mk(1, 2), "R10 set vs client clear");
    // R6: client clear drops all of one client
    op(0, 8'h10, 0, 1, mk(1, 7), "R6 set 1.7");
    op(1, 8'h14, mk(1, 7), 0, 0, "R6 en 1.7");
    op(1, 8'h38, 32'd1, 0, 0, "R6 client clear");
    // R2: send events, any identifier
    op(1, 8'h0C, 32'hDEAD_BEEF, 0, 0, "R2 send");
    op(1, 8'h0C, mk(3, 1), 0, 0, "R2 send again");

    // Random mix
    for (int i = 0; i < 1500; i++) begin
      logic [7:0] a;
      int c, s;
      a = addrs[$urandom_range(0, 5)];
      c = $urandom_range(0, NC);
      s = $urandom_range(0, NS);
      if (a == 8'h38) op(1, a, 32'(c), $urandom_range(0, 1) == 1,
                         mk($urandom_range(0, NC), $urandom_range(0, NS)), "rand");
      else            op($urandom_range(0, 3) != 0, a, mk(c, s), $urandom_range(0, 1) == 1,
                         mk($urandom_range(0, NC), $urandom_range(0, NS)), "rand");
    end

    // Drain loop: read, clear, repeat until all ones (R8, R5)
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NS; s++) op(1, 8'h14, mk(c, s), 0, 0, "R4 enable all");
    cnt = 0;
    id = bus_rdata;
    while (id != 32'hFFFF_FFFF && cnt < NC * NS + 2) begin
      op(1, 8'h1C, id, 0, 0, "R5 drain");
      id = bus_rdata;
      cnt++;
    end
    check("R8 drain ends idle", bus_rdata, 32'hFFFF_FFFF);
    check("R9 drain irq low", {31'd0, irq}, 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule